// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block turns a slow serial control stream into eight switch-enable levels. A host shifts a control word in one bit per rising edge of a serial clock. The word then reaches the eight outputs through a parallel latch. One output level of 1 turns its switch on. The word also leaves the block one stage at a time on a serial output, so several blocks can be chained on one data line.

The latch has two states set by a level input. While that input is low the latch is transparent, so the outputs follow the shift register as bits arrive. When it goes high the latch freezes the outputs, and the host can load the next word without disturbing the switches. A clear input turns every switch off and overrides all other inputs. Clear leaves the shift register contents alone.

All three serial-side inputs are asynchronous to the system clock. The system clock runs at least eight times faster than the serial clock and samples them through two-flop synchronizers. Every register in the block uses the system clock.

Top module: `serial_switch_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the latch. After reset all of `sw_on` is 0 and `ser_out` is 0.
- R2: Each rising edge of `ser_clk` moves stage i of the shift register to stage i+1 and loads `ser_in` into stage 0. Bit i of the register drives `sw_on[i]`. After eight edges the first bit sent is on `sw_on[7]` and the last bit sent is on `sw_on[0]`.
- R3: While `hold_en` and `clr_in` are both low, `sw_on` equals the shift register contents. A register change appears on `sw_on` no later than three system clock cycles after the serial clock edge.
- R4: When `hold_en` goes high, `sw_on` keeps the last value it showed while transparent. It does not change while `hold_en` stays high and clear stays low, whatever `ser_clk` and `ser_in` do.
- R5: The shift register keeps loading while the outputs are frozen. When `hold_en` returns low, the new contents appear on `sw_on`.
- R6: While `clr_in` is high, `sw_on` is all 0 whatever the other inputs do. This takes effect within two system clock cycles. If `hold_en` is high when clear is released, `sw_on` stays all 0 until `hold_en` goes low.
- R7: Clear does not alter the shift register. Serial edges seen during clear still shift it, and after clear ends with `hold_en` low, `sw_on` shows the register contents.
- R8: `ser_out` is stage 7 of the shift register. It is the bit that the next serial edge pushes out, so it can feed the `ser_in` of a following block.
- R9: A rise of `hold_en` and a rising serial edge may be sampled in the same system clock cycle. In that case the frozen value is the one shown before that shift, and the shift still lands in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial control data, sampled on the serial clock rise |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| hold_en | input | 1 | Low: outputs follow the register; high: outputs frozen |
| clr_in | input | 1 | High forces every switch off |
| ser_out | output | 1 | Last register stage, for cascading |
| sw_on | output | 8 | Switch enables, 1 = switch on |

## Verification
The block has two same-cycle collisions. In the first, a rising serial edge and the rise of `hold_en` pass their synchronizers together, so freezing the latch and shifting the register happen in one cycle. In the second, a serial edge lands while clear is active. The bench drives each pair on the same input edge, so both signals reach the synchronizers in one system clock cycle. For the first collision it checks that the frozen outputs hold the pre-shift word. For the second it checks that the outputs stay off. After the freeze or the clear is released, it checks that the shifted word appears. A queue-based reference model is compared with `sw_on` and `ser_out` on every cycle.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;

  // Serial-side controls, carried together through one synchronizer.
  typedef struct packed {
    logic clr;
    logic hold;
    logic din;
    logic sclk;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Which source drives the switch outputs.
  typedef enum logic [1:0] {
    VIEW_FOLLOW = 2'd0,
    VIEW_FROZEN = 2'd1,
    VIEW_OFF    = 2'd2
  } view_e;

  // Clear has priority over the latch state.
  function automatic view_e pick_view(input logic clr, input logic hold);
    if (clr)       return VIEW_OFF;
    else if (hold) return VIEW_FROZEN;
    else           return VIEW_FOLLOW;
  endfunction

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sw_edge.sv
module sw_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sw_shift_reg.sv
module sw_shift_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [N-1:0] q_o
);
  // Stage 0 takes the new bit, every other stage takes its lower neighbour.
  function automatic logic [N-1:0] push_bit(input logic [N-1:0] v, input logic b);
    logic [N-1:0] r;
    r[0] = b;
    for (int i = 1; i < N; i++) r[i] = v[i-1];
    return r;
  endfunction

  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (shift_i) q <= push_bit(q, bit_i);
  end

  assign q_o = q;
endmodule

// File: rtl/sw_out_latch.sv
module sw_out_latch
  import sw_ctrl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic [N-1:0] reg_i,
  output logic [N-1:0] sw_o
);
  logic [N-1:0] frz_q;
  view_e        view;

  assign view = pick_view(clr_i, hold_i);

  // frz_q tracks what the outputs last showed. It is zeroed by clear and
  // retained while frozen.
  always_ff @(posedge clk) begin
    if (rst) frz_q <= '0;
    else begin
      case (view)
        VIEW_OFF:    frz_q <= '0;
        VIEW_FOLLOW: frz_q <= reg_i;
        default:     frz_q <= frz_q;
      endcase
    end
  end

  always_comb begin
    case (view)
      VIEW_OFF:    sw_o = '0;
      VIEW_FROZEN: sw_o = frz_q;
      default:     sw_o = reg_i;
    endcase
  end
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl
  import sw_ctrl_pkg::*;
#(
  parameter int N_SW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_in,
  input  logic            ser_clk,
  input  logic            hold_en,
  input  logic            clr_in,
  output logic            ser_out,
  output logic [N_SW-1:0] sw_on
);
  localparam int MSB = N_SW - 1;

  ctl_t            raw_ctl;
  ctl_t            syn_ctl;
  logic            shift_evt;
  logic            din_sync;
  logic            le_sync;
  logic            clr_sync;
  logic [N_SW-1:0] sr_q;

  assign raw_ctl.clr  = clr_in;
  assign raw_ctl.hold = hold_en;
  assign raw_ctl.din  = ser_in;
  assign raw_ctl.sclk = ser_clk;

  sw_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw_ctl),
    .sync_o (syn_ctl)
  );

  assign din_sync = syn_ctl.din;
  assign le_sync  = syn_ctl.hold;
  assign clr_sync = syn_ctl.clr;

  sw_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (syn_ctl.sclk),
    .rise_o (shift_evt)
  );

  sw_shift_reg #(.N(N_SW)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift_evt),
    .bit_i   (din_sync),
    .q_o     (sr_q)
  );

  sw_out_latch #(.N(N_SW)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_sync),
    .hold_i (le_sync),
    .reg_i  (sr_q),
    .sw_o   (sw_on)
  );

  assign ser_out = sr_q[MSB];
endmodule

// File: rtl/sw_ctrl_checker.sv
module sw_ctrl_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_evt,
  input logic         din_sync,
  input logic         le_sync,
  input logic         clr_sync,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] sw_on
);
  AST_CLEAR_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    clr_sync |-> (sw_on == '0)); // R6

  AST_FOLLOWS_REG: assert property (@(posedge clk) disable iff (rst)
    (!clr_sync && !le_sync) |-> (sw_on == sr_q)); // R3

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (le_sync && $past(le_sync) && !clr_sync && !$past(clr_sync)) |-> $stable(sw_on)); // R4

  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(sr_q)); // R2

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (sr_q == {$past(sr_q[N-2:0]), $past(din_sync)})); // R2

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> !shift_evt); // R2

  AST_CLEAR_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
    (clr_sync && !shift_evt) |=> $stable(sr_q)); // R7
endmodule

bind serial_switch_ctrl sw_ctrl_checker #(.N(N_SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_evt (shift_evt),
  .din_sync  (din_sync),
  .le_sync   (le_sync),
  .clr_sync  (clr_sync),
  .sr_q      (sr_q),
  .sw_on     (sw_on)
);

// File: tb/serial_switch_ctrl_bench.sv
module serial_switch_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       ser_clk = 1'b0;
  logic       hold_en = 1'b0;
  logic       clr_in = 1'b0;
  logic       ser_out;
  logic [7:0] sw_on;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  running = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  serial_switch_ctrl u_serial_switch_ctrl (
    .clk (clk), .rst (rst), .ser_in (ser_in), .ser_clk (ser_clk),
    .hold_en (hold_en), .clr_in (clr_in), .ser_out (ser_out), .sw_on (sw_on)
  );

  // Reference model: input history kept in a queue (newest first); inputs
  // take effect two samples after they are driven.
  typedef struct packed { bit sc; bit d; bit le; bit cl; } samp_t;
  samp_t      hist[$];
  logic [7:0] m_reg = '0;
  logic [7:0] m_frz = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_reg = '0;
      m_frz = '0;
      hist  = '{samp_t'(0), samp_t'(0), samp_t'(0)};
    end else begin
      if (hist[1].cl)       m_frz = '0;
      else if (!hist[1].le) m_frz = m_reg;
      if (hist[1].sc && !hist[2].sc) m_reg = {m_reg[6:0], hist[1].d};
      hist.push_front('{sc: ser_clk, d: ser_in, le: hold_en, cl: clr_in});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      logic [7:0] exp_sw;
      string tag;
      exp_sw = hist[1].cl ? 8'h00 : (hist[1].le ? m_frz : m_reg);
      tag    = hist[1].cl ? "R6" : (hist[1].le ? "R4" : "R3");
      n_chk++;
      if (sw_on !== exp_sw) begin
        n_fail++;
        $display("FAIL %s model sw_on actual=%h expected=%h", tag, sw_on, exp_sw);
      end
      n_chk++;
      if (ser_out !== m_reg[7]) begin
        n_fail++;
        $display("FAIL R8 model ser_out actual=%b expected=%b", ser_out, m_reg[7]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_in  = b;
    ser_clk = 1'b0;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
  endtask

  // First bit sent is v[7], so it ends on switch 7.
  task automatic load(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    running = 1'b1;
    tick(1);
    check("R1 sw_on after reset", sw_on, 8'h00);
    check("R1 ser_out after reset", {7'b0, ser_out}, 8'h00);

    load(8'hB2);
    check("R2 word order", sw_on, 8'hB2);
    check("R8 last stage", {7'b0, ser_out}, 8'h01);
    send_bit(1'b0);
    check("R3 follows one shift", sw_on, 8'h64);
    check("R8 after shift", {7'b0, ser_out}, 8'h00);

    load(8'hFF);
    check("R2 all ones", sw_on, 8'hFF);
    load(8'h00);
    check("R2 all zeros", sw_on, 8'h00);
    load(8'h64);

    hold_en = 1'b1;
    tick(4);
    load(8'h5A);
    check("R4 frozen while loading", sw_on, 8'h64);
    check("R8 while frozen", {7'b0, ser_out}, 8'h00);
    hold_en = 1'b0;
    tick(4);
    check("R5 new word on release", sw_on, 8'h5A);

    clr_in = 1'b1;
    tick(3);
    check("R6 clear forces off", sw_on, 8'h00);
    send_bit(1'b1);
    check("R6 shift during clear", sw_on, 8'h00);
    hold_en = 1'b1;
    tick(4);
    clr_in = 1'b0;
    tick(4);
    check("R6 off after clear while frozen", sw_on, 8'h00);
    hold_en = 1'b0;
    tick(4);
    check("R7 register kept through clear", sw_on, 8'hB5);

    // Freeze and shift sampled in the same cycle.
    ser_in  = 1'b1;
    ser_clk = 1'b0;
    tick(4);
    hold_en = 1'b1;
    ser_clk = 1'b1;
    tick(6);
    check("R9 frozen pre-shift word", sw_on, 8'hB5);
    hold_en = 1'b0;
    tick(4);
    check("R9 shift landed", sw_on, 8'h6B);

    // Clear and shift sampled in the same cycle.
    ser_in  = 1'b0;
    ser_clk = 1'b0;
    tick(4);
    clr_in  = 1'b1;
    ser_clk = 1'b1;
    tick(6);
    check("R6 clear with shift", sw_on, 8'h00);
    clr_in = 1'b0;
    tick(4);
    check("R7 shift during clear kept", sw_on, 8'hD6);
    check("R8 cascade bit", {7'b0, ser_out}, 8'h01);

    tick(4);
    finish_run();
  end
endmodule